// File: doc/BRIEF.md
# Sectored Flash Erase and Program Engine

This block runs the timed erase and program operations of a 512K x 8 behavioural flash array whose sectors differ in size. Another block decodes the bus command sequences. It hands this engine one request at a time, each with an operation code, a byte address and a data byte. The engine finds the sector that owns the address and applies the boot-sector protection. It then counts the operation's duration in clock cycles and writes the array model at the end. The engine holds `busy` high for as long as an operation runs. It also keeps the address and data of the last accepted program for the status logic.

The array model keeps only `2**SLOT_W` bytes per sector. A byte lives at the sector that owns its full 19-bit address, in the slot given by the low `SLOT_W` address bits, so addresses that differ only above those bits within one sector alias. A read port returns the stored byte at any time. The boot lock is a one-way flag: no command clears it, and only the reset of the model does.

Top module: `flash_pe_engine`

## Requirements
- R1: Sector decode: 0x00000–0x03FFF is sector 0 (boot), 0x04000–0x05FFF is 1, 0x06000–0x07FFF is 2, 0x08000–0x0FFFF is 3, and each 64K range from 0x10000 up to 0x7FFFF is sector 3 plus address bits [18:16]. A byte is stored at its sector and at slot = address bits [SLOT_W-1:0].
- R2: After reset `busy`, `op_done` and `boot_locked` are 0, and every byte reads 0xFF.
- R3: A program (req_op 0) stores the old byte AND the request data, so it can only clear bits.
- R4: An accepted program holds `busy` for exactly PROG_CYCLES cycles. In the cycle after `busy` falls, `op_done` is high for one cycle and the new byte is visible.
- R5: A sector erase (req_op 1) holds `busy` for SERASE_CYCLES cycles, then sets every byte of the addressed sector to 0xFF and leaves all other sectors unchanged.
- R6: A chip erase (req_op 2) with the lock clear holds `busy` for CHIP_CYCLES cycles, then sets every byte of all sectors, boot included, to 0xFF.
- R7: A chip erase with the lock set erases every sector except the boot sector, whose contents stay unchanged.
- R8: A lock request (req_op 3) sets `boot_locked` on the next cycle with `op_done` and no busy period. Once set, `boot_locked` never clears, and a repeated lock request changes nothing.
- R9: While locked, a program or sector erase addressed to the boot sector raises `op_done` on the next cycle with no busy period and leaves the data unchanged.
- R10: A request presented while `busy` is high, including during a chip erase, is ignored. It causes no extra `op_done`, no data change and no change to the latched program address or data.
- R11: An accepted program latches its address and data onto `last_addr` and `last_data` on the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, honoured when idle |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 boot lock |
| req_addr | input | 19 | Byte address of the request |
| req_data | input | 8 | Program data |
| rd_addr | input | 19 | Read address |
| rd_data | output | 8 | Stored byte at rd_addr |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle completion pulse |
| boot_locked | output | 1 | Boot lockout active |
| last_addr | output | 19 | Address of last accepted program |
| last_data | output | 8 | Data of last accepted program |

## Verification
The bench builds the engine with PROG_CYCLES=5, SERASE_CYCLES=12 and CHIP_CYCLES=20. These short durations let every busy window be counted cycle by cycle, and they leave room for full chip erases in both lock states inside a short run. SLOT_W stays at 3, so each of the eleven sectors is fully visible through eight slots. Erasing one sector can then be checked against its neighbours on both sides of each sector boundary.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
    localparam int ADDR_W   = 19;
    localparam int DATA_W   = 8;
    localparam int NUM_SECT = 11;
    localparam int SECT_W   = 4;

    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_SERASE = 2'd1,
        OP_CHIP   = 2'd2,
        OP_LOCK   = 2'd3
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    typedef struct packed {
        st_e                st;
        op_e                op;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        logic               locked;
        logic               done;
        logic [ADDR_W-1:0]  last_addr;
        logic [DATA_W-1:0]  last_data;
    } eng_t;
endpackage

// File: rtl/flash_sector_map.sv
module flash_sector_map
    import flash_pe_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [SECT_W-1:0] sect
);
    always_comb begin
        if (addr[18:16] != 3'd0) begin
            sect = SECT_W'(3) + SECT_W'(addr[18:16]);
        end else if (addr[15]) begin
            sect = SECT_W'(3);
        end else begin
            case (addr[14:13])
                2'b11:   sect = SECT_W'(2);
                2'b10:   sect = SECT_W'(1);
                default: sect = SECT_W'(0);
            endcase
        end
    end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
    import flash_pe_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_en,
    input  logic [SECT_W-1:0]   prog_sect,
    input  logic [SLOT_W-1:0]   prog_slot,
    input  logic [DATA_W-1:0]   prog_data,
    input  logic [NUM_SECT-1:0] erase_mask,
    input  logic [SECT_W-1:0]   rd_sect,
    input  logic [SLOT_W-1:0]   rd_slot,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int SLOTS  = 1 << SLOT_W;
    localparam int BANK_W = SLOTS * DATA_W;

    logic [BANK_W-1:0] bank_rd [NUM_SECT];

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        logic [BANK_W-1:0] bank_d, bank_q;
        logic              hit;

        assign hit = prog_en && (prog_sect == SECT_W'(s));

        always_comb begin
            bank_d = bank_q;
            if (erase_mask[s]) begin
                bank_d = '1;
            end else if (hit) begin
                bank_d[prog_slot*DATA_W +: DATA_W] =
                    bank_q[prog_slot*DATA_W +: DATA_W] & prog_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) bank_q <= '1;
            else        bank_q <= bank_d;
        end

        assign bank_rd[s] = bank_q;
    end

    always_comb begin
        rd_data = '1;
        for (int s = 0; s < NUM_SECT; s++) begin
            if (rd_sect == SECT_W'(s)) begin
                rd_data = bank_rd[s][rd_slot*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
    import flash_pe_pkg::*;
#(
    parameter int SLOT_W        = 3,
    parameter int PROG_CYCLES   = 20,
    parameter int SERASE_CYCLES = 200,
    parameter int CHIP_CYCLES   = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              op_done,
    output logic              boot_locked,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);
    localparam int MAX_A = (PROG_CYCLES > SERASE_CYCLES) ? PROG_CYCLES : SERASE_CYCLES;
    localparam int MAX_C = (MAX_A > CHIP_CYCLES) ? MAX_A : CHIP_CYCLES;
    localparam int CNT_W = $clog2(MAX_C + 1);

    eng_t q, d;

    logic [SECT_W-1:0]   req_sect, op_sect, rd_sect;
    logic                tmr_load, tmr_zero, tmr_run;
    logic [CNT_W-1:0]    tmr_val;
    logic                prog_en;
    logic [NUM_SECT-1:0] erase_mask;
    logic                req_boot_blocked;

    flash_sector_map u_map_req (.addr(req_addr), .sect(req_sect));
    flash_sector_map u_map_op  (.addr(q.addr),   .sect(op_sect));
    flash_sector_map u_map_rd  (.addr(rd_addr),  .sect(rd_sect));

    flash_op_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .zero     (tmr_zero)
    );

    flash_array_model #(.SLOT_W(SLOT_W)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_en    (prog_en),
        .prog_sect  (op_sect),
        .prog_slot  (q.addr[SLOT_W-1:0]),
        .prog_data  (q.data),
        .erase_mask (erase_mask),
        .rd_sect    (rd_sect),
        .rd_slot    (rd_addr[SLOT_W-1:0]),
        .rd_data    (rd_data)
    );

    assign req_boot_blocked = q.locked && (req_sect == SECT_W'(0));
    assign tmr_run          = (q.st == ST_RUN);

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        prog_en    = 1'b0;
        erase_mask = '0;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    case (op_e'(req_op))
                        OP_PROG: begin
                            if (req_boot_blocked) begin
                                d.done = 1'b1;
                            end else begin
                                d.st        = ST_RUN;
                                d.op        = OP_PROG;
                                d.addr      = req_addr;
                                d.data      = req_data;
                                d.last_addr = req_addr;
                                d.last_data = req_data;
                                tmr_load    = 1'b1;
                                tmr_val     = CNT_W'(PROG_CYCLES - 1);
                            end
                        end
                        OP_SERASE: begin
                            if (req_boot_blocked) begin
                                d.done = 1'b1;
                            end else begin
                                d.st     = ST_RUN;
                                d.op     = OP_SERASE;
                                d.addr   = req_addr;
                                tmr_load = 1'b1;
                                tmr_val  = CNT_W'(SERASE_CYCLES - 1);
                            end
                        end
                        OP_CHIP: begin
                            d.st     = ST_RUN;
                            d.op     = OP_CHIP;
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(CHIP_CYCLES - 1);
                        end
                        default: begin
                            d.locked = 1'b1;
                            d.done   = 1'b1;
                        end
                    endcase
                end
            end
            default: begin
                if (tmr_zero) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    case (q.op)
                        OP_PROG:   prog_en = 1'b1;
                        OP_SERASE: erase_mask[op_sect] = 1'b1;
                        OP_CHIP: begin
                            erase_mask    = '1;
                            erase_mask[0] = !q.locked;
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= ST_IDLE;
            q.op        <= OP_PROG;
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.st == ST_RUN);
    assign op_done     = q.done;
    assign boot_locked = q.locked;
    assign last_addr   = q.last_addr;
    assign last_data   = q.last_data;
endmodule

// File: rtl/flash_pe_checker.sv
module flash_pe_checker
    import flash_pe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              busy,
    input logic              op_done,
    input logic              boot_locked,
    input logic [ADDR_W-1:0] last_addr,
    input logic [DATA_W-1:0] last_data
);
    logic in_boot;
    assign in_boot = (req_addr < 19'h04000);

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> !busy); // R4

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_locked |=> boot_locked); // R8

    AST_CHIP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_op == 2'd2) |=> busy); // R6

    AST_LOCKED_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && boot_locked && req_valid && req_op[1] == 1'b0 && in_boot)
        |=> (!busy && op_done)); // R9

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(last_addr) && $stable(last_data) && $stable(boot_locked))); // R10

    AST_BOOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_locked && $past(boot_locked) && rd_addr < 19'h04000 && $stable(rd_addr))
        |-> $stable(rd_data)); // R7

    AST_PROG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_op == 2'd0 && !(boot_locked && in_boot))
        |=> (last_addr == $past(req_addr) && last_data == $past(req_data))); // R11
endmodule

bind flash_pe_engine flash_pe_checker u_chk (.*);

// File: tb/sim_flash_pe_engine.sv
module sim_flash_pe_engine;
    localparam int PC = 5;
    localparam int SC = 12;
    localparam int CC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [18:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy, op_done, boot_locked;
    logic [18:0] last_addr;
    logic [7:0]  last_data;

    int errors = 0;
    int checks = 0;
    int exp_q[$];
    logic [7:0] em [11][8];

    always #2 clk = ~clk;

    flash_pe_engine #(.SLOT_W(3), .PROG_CYCLES(PC), .SERASE_CYCLES(SC), .CHIP_CYCLES(CC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .op_done(op_done), .boot_locked(boot_locked),
        .last_addr(last_addr), .last_data(last_data)
    );

    function automatic int sect_of(logic [18:0] a);
        if (a < 19'h04000) return 0;
        if (a < 19'h06000) return 1;
        if (a < 19'h08000) return 2;
        if (a < 19'h10000) return 3;
        return 3 + int'(a / 19'h10000);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // monitor: pops the expected busy length at each completion pulse
    int bc = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) bc++;
            if (op_done) begin
                if (exp_q.size() == 0) chk("R10 unexpected op_done", 1, 0);
                else chk("R4/R5/R6/R9 busy length", bc, exp_q.pop_front());
                bc = 0;
            end
        end
    end

    task automatic issue(int op, logic [18:0] a, logic [7:0] dt, int blen, bit acc);
        if (acc) exp_q.push_back(blen);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = dt;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!op_done) @(negedge clk);
    endtask

    task automatic rd(logic [18:0] a, string req);
        @(negedge clk);
        rd_addr = a;
        #1 chk(req, rd_data, em[sect_of(a)][a[2:0]]);
    endtask

    task automatic model_erase(int s);
        for (int k = 0; k < 8; k++) em[s][k] = 8'hFF;
    endtask

    task automatic prog(logic [18:0] a, logic [7:0] dt);
        bit blocked = boot_locked && sect_of(a) == 0;
        issue(0, a, dt, blocked ? 0 : PC, 1);
        wait_done();
        if (!blocked) em[sect_of(a)][a[2:0]] &= dt;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk("watchdog", 1, 0);
        summary();
        $finish;
    end

    initial begin
        for (int s = 0; s < 11; s++) model_erase(s);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 busy", busy, 0);
        chk("R2 done", op_done, 0);
        chk("R2 lock", boot_locked, 0);
        rd(19'h00000, "R2 erased boot");
        rd(19'h7FFFF, "R2 erased main8");

        prog(19'h08003, 8'h5A);
        chk("R11 last_addr", last_addr, 19'h08003);
        chk("R11 last_data", last_data, 8'h5A);
        rd(19'h08003, "R3 program");
        prog(19'h08003, 8'h0F);
        rd(19'h08003, "R3 and-only");

        prog(19'h04001, 8'h12);
        prog(19'h05FF9, 8'hE1);
        prog(19'h06001, 8'h34);
        prog(19'h0FFF9, 8'h77);
        prog(19'h10001, 8'h9C);
        prog(19'h70002, 8'h56);
        prog(19'h00001, 8'h78);
        rd(19'h04001, "R1 param1");
        rd(19'h06001, "R1 param2");
        rd(19'h70002, "R1 main8");

        // R10: second request while busy is ignored
        issue(0, 19'h20000, 8'h00, PC, 1);
        issue(0, 19'h30000, 8'h00, 0, 0);
        wait_done();
        em[sect_of(19'h20000)][0] = 8'h00;
        chk("R10 last_addr kept", last_addr, 19'h20000);
        rd(19'h30000, "R10 ignored write");

        // R5 sector erase of parameter sector 1
        issue(1, 19'h05FFF, 8'h00, SC, 1);
        wait_done();
        model_erase(1);
        rd(19'h04001, "R5 erased");
        rd(19'h05FF9, "R5 erased alias");
        rd(19'h06001, "R5 neighbour up");
        rd(19'h00001, "R5 neighbour down");
        issue(1, 19'h0FFFF, 8'h00, SC, 1);
        wait_done();
        model_erase(3);
        rd(19'h08003, "R1 main1 erased");
        rd(19'h10001, "R1 main2 kept");

        // R6 chip erase unlocked, with an ignored request in the middle
        prog(19'h00002, 8'h00);
        issue(2, 19'h0, 8'h0, CC, 1);
        issue(1, 19'h70000, 8'h00, 0, 0);
        wait_done();
        for (int s = 0; s < 11; s++) model_erase(s);
        rd(19'h00002, "R6 boot erased");
        rd(19'h70002, "R6 main erased");
        rd(19'h20000, "R6 main3 erased");

        // R8 lock
        prog(19'h00003, 8'hA5);
        prog(19'h30000, 8'h11);
        issue(3, 19'h0, 8'h0, 0, 1);
        chk("R8 lock set", boot_locked, 1);
        wait_done();

        // R9 blocked ops on boot
        prog(19'h00003, 8'h00);
        rd(19'h00003, "R9 program blocked");
        issue(1, 19'h03FFF, 8'h00, 0, 1);
        wait_done();
        rd(19'h00003, "R9 erase blocked");
        prog(19'h04000, 8'h3C);
        rd(19'h04000, "R9 param still writable");

        // R7 chip erase while locked
        issue(2, 19'h0, 8'h0, CC, 1);
        wait_done();
        for (int s = 1; s < 11; s++) model_erase(s);
        rd(19'h00003, "R7 boot kept");
        rd(19'h30000, "R7 main erased");
        rd(19'h04000, "R7 param erased");

        issue(3, 19'h0, 8'h0, 0, 1);
        wait_done();
        @(negedge clk);
        chk("R8 lock persists", boot_locked, 1);
        rd(19'h00003, "R8 data after relock");

        repeat (5) @(negedge clk);
        chk("R10 queue drained", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule